// File: doc/BRIEF.md
# Memory-Mapped Serial Port Registers

This block lets an 8-bit processor drive a byte-wide asynchronous serial link through two fixed addresses in its memory map. One address is the data register. A write to it launches a frame on the transmit line, and a read from it returns the last byte captured from the receive line. The other address is the status register. Reading it reports whether the transmitter is busy and whether a received byte is waiting. Writing any value to it empties the receive buffer and allows the next byte to be taken.

The serial side runs from its own fast clock, and the processor bus runs from a slower, unrelated clock. Every control and status signal between the two passes through a two-flop synchronizer. A transmit request is sent as a toggle and acknowledged by a returned toggle. The frame format is one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. The bit length is a parameter given in serial clock cycles. Reception is single-shot: after one byte has been captured, the receiver ignores the line until software clears the buffer again. Reception is also disarmed after reset, so software must clear the buffer once before the first byte.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, the status register reads 8'h00, the data register reads 8'h00, and `serial_out` is held at 1.
- R2: A write to the data address (default 8'hFE) while the transmitter is idle sends the written byte as 8N1 on `serial_out`. The frame is a 0 start bit, then data bits least significant first, then a 1 stop bit, each bit lasting CLKS_PER_BIT serial clock cycles.
- R3: Status bit 0 (transmit busy) reads 1 from the bus cycle after an accepted data write until the stop bit has completed. It then returns to 0 within a few bus cycles.
- R4: A write to the data address while status bit 0 is 1 is ignored. The frame in progress is unchanged and no further frame follows.
- R5: After reset the receiver is disarmed. A frame arriving before the first write to the status address leaves status bit 1 at 0.
- R6: A write of any value to the status address (default 8'hFF) clears status bit 1 and arms the receiver. The next valid frame sets status bit 1 (receive full), and a read of the data address then returns that byte.
- R7: While status bit 1 is 1, further frames are ignored. The data register keeps the first byte until the status address is written.
- R8: Status bits 7 to 2 always read 0.
- R9: The receiver samples each bit at its middle. A frame whose stop bit is sampled as 0 is discarded, and the receiver stays armed for the next frame.
- R10: `rd_data` is 0 when `rd_en` is low or when the address matches neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Processor bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| ser_clk | input | 1 | Serial clock (nominally 12 MHz) |
| ser_rst_n | input | 1 | Active-low asynchronous reset, serial domain |
| addr | input | 8 | Bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from address and strobe |
| serial_in | input | 1 | Receive line, asynchronous |
| serial_out | output | 1 | Transmit line, idle high |

## Verification
The hardest situation to reach is a frame that arrives while the receive buffer is already full. This needs a clear, a complete frame, and a second complete frame with no clear in between. The bench builds this sequence from whole frames it drives bit by bit. It then reads the data register and expects the first byte.

A second hard case is a stop bit that is low at mid-bit but returns high soon after. The bench holds the line low for about three quarters of a bit so that the receiver rejects the frame and sees no false start. It then sends a good frame to show that the receiver is still armed.

Both transmit cases are checked while a frame is in flight: the status read during the frame, and a second data write that must be dropped.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int BYTE_W        = 8;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_FULL_BIT = 1;

  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP
  } frame_st_t;

  // Count at which the receiver checks the start bit (middle of the bit).
  function automatic int half_bit(input int cpb);
    return (cpb / 2 > 0) ? cpb / 2 : 1;
  endfunction

  // Assemble the status byte from its two flags.
  function automatic logic [BYTE_W-1:0] status_word(input logic busy, input logic full);
    logic [BYTE_W-1:0] w;
    w = '0;
    w[STAT_BUSY_BIT] = busy;
    w[STAT_FULL_BIT] = full;
    return w;
  endfunction

endpackage

// File: rtl/sio_sync2.sv
module sio_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 104,
  parameter int DW           = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] TOP  = IW'(DW - 1);

  frame_st_t     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic          bit_end;

  assign bit_end = (cnt == LAST);
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
      txd <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sh  <= data;
          cnt <= '0;
          st  <= S_START;
          txd <= 1'b0;
        end
        S_START: if (bit_end) begin
          cnt <= '0;
          idx <= '0;
          st  <= S_DATA;
          txd <= sh[0];
        end else cnt <= cnt + 1'b1;
        S_DATA: if (bit_end) begin
          cnt <= '0;
          if (idx == TOP) begin
            st  <= S_STOP;
            txd <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            sh  <= sh >> 1;
            txd <= sh[1];
          end
        end else cnt <= cnt + 1'b1;
        default: if (bit_end) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 104,
  parameter int DW           = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd_async,
  output logic          valid,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST    = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(half_bit(CLKS_PER_BIT) - 1);
  localparam logic [IW-1:0] TOP     = IW'(DW - 1);

  frame_st_t     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic          rxd;
  logic          bit_end;

  // Idle line is high, so the synchronizer resets to 1.
  sio_sync2 #(.W(1), .RST_VAL(1'b1)) i_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd_async), .q(rxd)
  );

  assign bit_end = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: if (!rxd) begin
          cnt <= '0;
          st  <= S_START;
        end
        S_START: if (cnt == HALF_M1) begin
          cnt <= '0;
          idx <= '0;
          st  <= rxd ? S_IDLE : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (bit_end) begin
          cnt <= '0;
          sh  <= {rxd, sh[DW-1:1]};
          if (idx == TOP) st <= S_STOP;
          else idx <= idx + 1'b1;
        end else cnt <= cnt + 1'b1;
        default: if (bit_end) begin
          cnt <= '0;
          st  <= S_IDLE;
          if (rxd) begin
            valid <= 1'b1;
            data  <= sh;
          end
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sio_pkg::*;
#(
  parameter int              CLKS_PER_BIT = 104,
  parameter int              ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 8'hFE,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'hFF
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              ser_clk,
  input  logic              ser_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              serial_in,
  output logic              serial_out
);
  // ---------------- bus domain ----------------
  logic              wr_data_hit, wr_stat_hit, tx_accept, tx_busy_bus;
  logic              req_tgl, clr_tgl, tx_pend;
  logic [BYTE_W-1:0] tx_hold;
  logic              rx_full;
  logic [BYTE_W-1:0] rx_buf;
  logic              ack_s, busy_s, done_s, done_prev, done_edge;

  // ---------------- serial domain -------------
  logic              req_s, clr_s, req_prev, clr_prev;
  logic              tx_start_u, tx_busy_u, clr_edge_u;
  logic              ack_tgl_u, armed_u, done_tgl_u;
  logic              rx_valid_u, rx_capture_u;
  logic [BYTE_W-1:0] rx_byte_u, rx_hold_u;

  assign wr_data_hit = wr_en && (addr == DATA_ADDR);
  assign wr_stat_hit = wr_en && (addr == STAT_ADDR);
  assign tx_pend     = req_tgl ^ ack_s;
  assign tx_busy_bus = tx_pend | busy_s;
  assign tx_accept   = wr_data_hit && !tx_busy_bus;
  assign done_edge   = done_s ^ done_prev;

  sio_sync2 #(.W(3)) i_to_bus (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .d({ack_tgl_u, tx_busy_u, done_tgl_u}),
    .q({ack_s, busy_s, done_s})
  );

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_tgl   <= 1'b0;
      clr_tgl   <= 1'b0;
      tx_hold   <= '0;
      rx_full   <= 1'b0;
      rx_buf    <= '0;
      done_prev <= 1'b0;
    end else begin
      done_prev <= done_s;
      if (tx_accept) begin
        tx_hold <= wr_data;
        req_tgl <= ~req_tgl;
      end
      if (wr_stat_hit) begin
        rx_full <= 1'b0;
        clr_tgl <= ~clr_tgl;
      end else if (done_edge && !rx_full) begin
        rx_full <= 1'b1;
        rx_buf  <= rx_hold_u;   // held stable by the disarmed serial side
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == DATA_ADDR)      rd_data = rx_buf;
      else if (addr == STAT_ADDR) rd_data = status_word(tx_busy_bus, rx_full);
    end
  end

  // ---------------- serial side ----------------
  sio_sync2 #(.W(2)) i_to_ser (
    .clk(ser_clk), .rst_n(ser_rst_n),
    .d({req_tgl, clr_tgl}),
    .q({req_s, clr_s})
  );

  assign tx_start_u   = req_s ^ req_prev;
  assign clr_edge_u   = clr_s ^ clr_prev;
  assign rx_capture_u = rx_valid_u && armed_u;

  always_ff @(posedge ser_clk or negedge ser_rst_n) begin
    if (!ser_rst_n) begin
      req_prev   <= 1'b0;
      clr_prev   <= 1'b0;
      ack_tgl_u  <= 1'b0;
      armed_u    <= 1'b0;
      done_tgl_u <= 1'b0;
      rx_hold_u  <= '0;
    end else begin
      req_prev <= req_s;
      clr_prev <= clr_s;
      if (tx_start_u) ack_tgl_u <= req_s;
      if (rx_capture_u) begin
        rx_hold_u  <= rx_byte_u;
        done_tgl_u <= ~done_tgl_u;
        armed_u    <= 1'b0;
      end
      if (clr_edge_u) armed_u <= 1'b1;
    end
  end

  sio_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DW(BYTE_W)) i_tx (
    .clk(ser_clk), .rst_n(ser_rst_n), .start(tx_start_u),
    .data(tx_hold), .txd(serial_out), .busy(tx_busy_u)
  );

  sio_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DW(BYTE_W)) i_rx (
    .clk(ser_clk), .rst_n(ser_rst_n), .rxd_async(serial_in),
    .valid(rx_valid_u), .data(rx_byte_u)
  );
endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hFF
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              ser_clk,
  input logic              ser_rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              serial_out,
  input logic              tx_accept,
  input logic              tx_busy_bus,
  input logic              wr_data_hit,
  input logic              wr_stat_hit,
  input logic              req_tgl,
  input logic              rx_full,
  input logic [7:0]        rx_buf,
  input logic              tx_busy_u,
  input logic              tx_start_u
);
  p_line_idle_r1: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    !tx_busy_u |-> serial_out);

  p_start_bit_r2: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    tx_start_u |=> (!serial_out && tx_busy_u));

  p_busy_after_accept_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    tx_accept |=> tx_busy_bus);

  p_drop_while_busy_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wr_data_hit && tx_busy_bus) |=> $stable(req_tgl));

  p_clear_empties_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    wr_stat_hit |=> !rx_full);

  p_full_holds_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rx_full && !wr_stat_hit) |=> (rx_full && $stable(rx_buf)));

  p_upper_zero_r8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rd_en && addr == STAT_ADDR) |-> (rd_data[7:2] == 6'd0));

  p_quiet_read_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !rd_en |-> (rd_data == 8'd0));
endmodule

bind serial_port_regs serial_port_regs_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) i_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n),
  .addr(addr), .rd_en(rd_en), .rd_data(rd_data), .serial_out(serial_out),
  .tx_accept(tx_accept), .tx_busy_bus(tx_busy_bus), .wr_data_hit(wr_data_hit),
  .wr_stat_hit(wr_stat_hit), .req_tgl(req_tgl), .rx_full(rx_full), .rx_buf(rx_buf),
  .tx_busy_u(tx_busy_u), .tx_start_u(tx_start_u)
);

// File: tb/test_serial_port_regs.sv
`timescale 1ns/1ps
module test_serial_port_regs;
  localparam int CPB    = 16;
  localparam int BIT_NS = CPB * 5;
  localparam logic [7:0] DA = 8'hFE;
  localparam logic [7:0] SA = 8'hFF;

  logic bus_clk = 0, ser_clk = 0, bus_rst_n = 0, ser_rst_n = 0;
  logic [7:0] addr = '0, wr_data = '0;
  logic rd_en = 0, wr_en = 0, serial_in = 1;
  logic [7:0] rd_data;
  logic serial_out;

  int vectors = 0, errors = 0;
  bit finished = 0;

  always #2.5 ser_clk = ~ser_clk;   // 200 MHz serial clock
  always #10  bus_clk = ~bus_clk;

  serial_port_regs #(.CLKS_PER_BIT(CPB)) i_serial_port_regs (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .serial_in(serial_in), .serial_out(serial_out)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge bus_clk); addr = a; wr_data = d; wr_en = 1;
    @(posedge bus_clk); #2 wr_en = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge bus_clk); addr = a; rd_en = 1;
    #2 d = rd_data; rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  // Wait for a start bit, then sample each bit at its middle.
  task automatic capture(output logic [7:0] d, output bit ok);
    ok = 0; d = 'x;
    for (int i = 0; i < 4000 && serial_out; i++) @(negedge ser_clk);
    if (serial_out) return;
    #(BIT_NS / 2);
    if (serial_out !== 1'b0) return;
    for (int b = 0; b < 8; b++) begin #(BIT_NS); d[b] = serial_out; end
    #(BIT_NS);
    ok = (serial_out === 1'b1);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit good_stop);
    serial_in = 0; #(BIT_NS);
    for (int b = 0; b < 8; b++) begin serial_in = d[b]; #(BIT_NS); end
    if (good_stop) begin serial_in = 1; #(BIT_NS); end
    else begin serial_in = 0; #(BIT_NS * 3 / 4); serial_in = 1; #(BIT_NS); end
    serial_in = 1; #(BIT_NS);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(SA, v);  check8("R1 status after reset", v, 8'h00);
    bus_rd(DA, v);  check8("R1 data after reset", v, 8'h00);
    check8("R1 line idle", {7'd0, serial_out}, 8'h01);
    bus_rd(8'h10, v); check8("R10 unmapped read", v, 8'h00);
    #1 check8("R10 no strobe", rd_data, 8'h00);
  endtask

  task automatic t_rx_unarmed;
    logic [7:0] v;
    send_frame(8'h5A, 1); idle(8);
    bus_rd(SA, v); check8("R5 frame before arming", v, 8'h00);
  endtask

  task automatic t_tx(input logic [7:0] d);
    logic [7:0] got, v; bit ok;
    fork
      capture(got, ok);
      begin bus_wr(DA, d); bus_rd(SA, v); check8("R3 busy during frame", v, 8'h01); end
    join
    check8("R2 frame ok", {7'd0, ok}, 8'h01);
    check8("R2 frame data", got, d);
    idle(20);
    bus_rd(SA, v); check8("R3 busy cleared", v, 8'h00);
  endtask

  task automatic t_tx_busy;
    logic [7:0] got, v; bit ok;
    fork
      capture(got, ok);
      begin bus_wr(DA, 8'hA5); idle(2); bus_wr(DA, 8'h3C); end
    join
    check8("R4 first frame kept", got, 8'hA5);
    capture(got, ok);
    check8("R4 no second frame", {7'd0, ok}, 8'h00);
    bus_rd(SA, v); check8("R4 idle after drop", v, 8'h00);
  endtask

  task automatic t_rx(input logic [7:0] d);
    logic [7:0] v;
    bus_wr(SA, 8'h5C);
    bus_rd(SA, v); check8("R6 clear empties", v, 8'h00);
    send_frame(d, 1); idle(8);
    bus_rd(SA, v); check8("R6 full set", v, 8'h02);
    bus_rd(DA, v); check8("R6 byte read", v, d);
  endtask

  task automatic t_rx_full;
    logic [7:0] v;
    send_frame(8'h3C, 1); idle(8);
    bus_rd(DA, v); check8("R7 byte held while full", v, 8'h81);
    bus_rd(SA, v); check8("R7 still full", v, 8'h02);
    bus_wr(SA, 8'h00);
    bus_rd(SA, v); check8("R6 cleared after full", v, 8'h00);
  endtask

  task automatic t_bad_stop;
    logic [7:0] v;
    send_frame(8'h77, 0); idle(8);
    bus_rd(SA, v); check8("R9 bad stop discarded", v, 8'h00);
    send_frame(8'h44, 1); idle(8);
    bus_rd(SA, v); check8("R9 still armed", v, 8'h02);
    bus_rd(DA, v); check8("R9 next byte", v, 8'h44);
  endtask

  initial begin
    #33 bus_rst_n = 1; ser_rst_n = 1;
    idle(3);
    t_reset();
    t_rx_unarmed();
    t_tx(8'hA5);
    t_tx(8'h01);
    t_tx_busy();
    t_rx(8'hC3);
    t_rx(8'h81);
    t_rx_full();
    t_bad_stop();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule